// File: doc/BRIEF.md
# Double-Buffered Index Sequence Player

This block replays a programmed list of trace-cache line indices, one index per clock, so that the cache beside it can present one microcode line every cycle at the execution rate. Each trace cache has one such player. The player keeps two index stores. The active store drives playback. The shadow store is filled one entry at a time while the active list is still being replayed. Because of this, loading a new list and replaying the current one overlap and do not compete for the same storage.

A start pulse commits the shadow store. Its contents and the current length setting are copied into the active side, and replay begins from entry zero. A start pulse is dropped when nothing has been loaded since the last commit. When a start pulse arrives in the middle of a replay, it is held until the final index of that replay has gone out. The new list then follows with no idle cycle between the two. The reset input is assumed to be deasserted synchronously to the clock by logic upstream.

Top module: `seq_replay_mgr`

## Requirements
- R1: After reset, rd_valid, busy and next_ready are all low, and the length setting is DEPTH.
- R2: Each cycle with load_en high writes load_idx into the shadow store at the write position, then advances that position by one, wrapping from DEPTH-1 to 0. next_ready is high from the cycle after the first such write.
- R3: A cycle with len_set high records len_val as the length setting, after clamping: 0 becomes 1 and any value above DEPTH becomes DEPTH.
- R4: If start is high while next_ready is high and no replay is running, rd_valid rises in the next cycle. rd_idx then shows shadow entries 0, 1, ... up to length-1, one per cycle.
- R5: A start pulse while next_ready is low has no effect: it starts nothing and is not remembered.
- R6: next_ready falls in the cycle after a commit, unless load_en is high in the commit cycle. Loads made during a replay do not change the indices being replayed.
- R7: A start pulse accepted during a replay is held until the last index of that replay. The committed list's entry 0 appears in the very next cycle, with rd_valid staying high.
- R8: busy and rd_valid are high exactly while a replay is running. Both fall in the cycle after the final index has been presented.
- R9: The length used by a replay is the setting held when it is committed. A len_set during a replay affects only later commits.
- R10: A load in the commit cycle goes into entry 0 of the emptied shadow store, and next_ready stays high. The commit copies the store as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Execution clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one index into the shadow store |
| load_idx | input | IDX_W | Index value to write |
| len_set | input | 1 | Record a new length setting |
| len_val | input | LEN_W | Requested length, clamped to 1..DEPTH |
| start | input | 1 | Commit the shadow store and begin replay |
| rd_idx | output | IDX_W | Cache index being replayed |
| rd_valid | output | 1 | rd_idx is meaningful this cycle |
| busy | output | 1 | A replay is running |
| next_ready | output | 1 | Shadow store holds an uncommitted list |

## Verification
Some properties are checked on every cycle. The read position stays below the latched length. A replay never begins unless the shadow store was ready. A held start produces no gap. next_ready sets after a load and clears after a commit that has no load. The length setting stays within 1..DEPTH. Other behaviour can only be shown by the bench scenarios comparing rd_idx against a list model: the exact order of replayed indices, the clamping of extreme lengths, loads that land in the commit cycle, and length changes made during a replay.

// File: rtl/seq_mgr_pkg.sv
package seq_mgr_pkg;
  // Clamp a requested replay length into 1..hi.
  function automatic int unsigned sm_clamp(input int unsigned v, input int unsigned hi);
    if (v == 0) return 1;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/seq_len_reg.sv
module seq_len_reg #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_set,
  input  logic [LEN_W-1:0] len_val,
  output logic [LEN_W-1:0] len_o
);
  import seq_mgr_pkg::*;

  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (len_set) len_d = LEN_W'(sm_clamp(int'(len_val), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= LEN_W'(DEPTH);
    else        len_q <= len_d;
  end

  assign len_o = len_q;

  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(DEPTH)));
endmodule

// File: rtl/seq_next_buf.sv
module seq_next_buf #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_en,
  input  logic [IDX_W-1:0]            load_idx,
  input  logic                        swap,
  output logic [DEPTH-1:0][IDX_W-1:0] buf_o,
  output logic                        ready_o
);
  logic [DEPTH-1:0][IDX_W-1:0] buf_q, buf_d;
  logic [PTR_W-1:0]            wp_q, wp_d, wp_base;
  logic                        rdy_q, rdy_d;

  always_comb begin
    wp_base = swap ? '0 : wp_q;
    buf_d   = buf_q;
    wp_d    = wp_base;
    rdy_d   = rdy_q & ~swap;
    if (load_en) begin
      buf_d[wp_base] = load_idx;
      wp_d  = (wp_base == PTR_W'(DEPTH - 1)) ? '0 : wp_base + PTR_W'(1);
      rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      wp_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      wp_q  <= wp_d;
      rdy_q <= rdy_d;
    end
  end

  assign buf_o   = buf_q;
  assign ready_o = rdy_q;

  a_r2_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ready_o);
  a_r6_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !load_en) |=> !ready_o);
  a_r10_commit_load_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && load_en) |=> (buf_q[0] == $past(load_idx)));
endmodule

// File: rtl/seq_playback.sv
module seq_playback #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        ready,
  input  logic [DEPTH-1:0][IDX_W-1:0] nxt_buf,
  input  logic [LEN_W-1:0]            len,
  output logic                        swap,
  output logic [IDX_W-1:0]            rd_idx,
  output logic                        playing
);
  logic [DEPTH-1:0][IDX_W-1:0] cur_q, cur_d;
  logic [PTR_W-1:0]            rp_q, rp_d;
  logic [LEN_W-1:0]            plen_q, plen_d;
  logic                        play_q, play_d;
  logic                        pend_q, pend_d;
  logic                        last;

  always_comb begin
    last   = play_q && (LEN_W'(rp_q) == plen_q - LEN_W'(1));
    swap   = ready && (start || pend_q) && (!play_q || last);
    cur_d  = cur_q;
    plen_d = plen_q;
    play_d = play_q;
    rp_d   = rp_q;
    pend_d = pend_q || (start && ready);
    if (swap) begin
      cur_d  = nxt_buf;
      plen_d = len;
      play_d = 1'b1;
      rp_d   = '0;
      pend_d = 1'b0;
    end else if (play_q) begin
      if (last) play_d = 1'b0;
      else      rp_d   = rp_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      rp_q   <= '0;
      plen_q <= LEN_W'(1);
      play_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      rp_q   <= rp_d;
      plen_q <= plen_d;
      play_q <= play_d;
      pend_q <= pend_d;
    end
  end

  assign rd_idx  = cur_q[rp_q];
  assign playing = play_q;

  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    play_q |-> (LEN_W'(rp_q) < plen_q));
  a_r5_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_q) |-> $past(ready));
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last && pend_q) |=> (play_q && rp_q == '0));
  a_r8_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !swap) |=> !play_q);
endmodule

// File: rtl/seq_replay_mgr.sv
module seq_replay_mgr #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             len_set,
  input  logic [LEN_W-1:0] len_val,
  input  logic             start,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             busy,
  output logic             next_ready
);
  logic [DEPTH-1:0][IDX_W-1:0] shadow;
  logic [LEN_W-1:0]            len_cur;
  logic                        swap, ready, playing;

  seq_len_reg #(.DEPTH(DEPTH)) u_len (
    .clk(clk), .rst_n(rst_n), .len_set(len_set), .len_val(len_val), .len_o(len_cur)
  );

  seq_next_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_next (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .swap(swap), .buf_o(shadow), .ready_o(ready)
  );

  seq_playback #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_play (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .nxt_buf(shadow),
    .len(len_cur), .swap(swap), .rd_idx(rd_idx), .playing(playing)
  );

  assign rd_valid   = playing;
  assign busy       = playing;
  assign next_ready = ready;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !next_ready));
endmodule

// File: tb/seq_replay_mgr_test.sv
module seq_replay_mgr_test;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_en = 0, len_set = 0, start = 0;
  logic [IDX_W-1:0] load_idx = '0;
  logic [LEN_W-1:0] len_val = '0;
  logic [IDX_W-1:0] rd_idx;
  logic rd_valid, busy, next_ready;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  int m_nxt[DEPTH], m_cur[DEPTH];
  int m_wp, m_len, m_plen, m_rp;
  bit m_rdy, m_play, m_pend;

  always #10 clk = ~clk;

  seq_replay_mgr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .len_set(len_set), .len_val(len_val), .start(start),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .busy(busy), .next_ready(next_ready)
  );

  function automatic int clamp_exp(int v);
    if (v == 0) return 1;
    if (v > DEPTH) return DEPTH;
    return v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "rd_valid", int'(rd_valid), int'(m_play));
    chk(req, "busy", int'(busy), int'(m_play));
    chk(req, "next_ready", int'(next_ready), int'(m_rdy));
    if (m_play) chk(req, "rd_idx", int'(rd_idx), m_cur[m_rp]);
  endtask

  task automatic model_edge(bit ld, int li, bit ls, int lv, bit st);
    bit last, sw;
    int wpu;
    last = m_play && (m_rp == m_plen - 1);
    sw = m_rdy && (st || m_pend) && (!m_play || last);
    wpu = sw ? 0 : m_wp;
    if (sw) begin
      for (int i = 0; i < DEPTH; i++) m_cur[i] = m_nxt[i];
      m_plen = m_len; m_play = 1; m_rp = 0; m_pend = 0; m_rdy = 0;
    end else begin
      if (st && m_rdy) m_pend = 1;
      if (m_play) begin
        if (last) m_play = 0; else m_rp++;
      end
    end
    m_wp = wpu;
    if (ld) begin
      m_nxt[wpu] = li;
      m_wp = (wpu + 1) % DEPTH;
      m_rdy = 1;
    end
    if (ls) m_len = clamp_exp(lv);
  endtask

  task automatic step(string req, bit ld, int li, bit ls, int lv, bit st);
    load_en = ld; load_idx = IDX_W'(li); len_set = ls; len_val = LEN_W'(lv); start = st;
    @(posedge clk);
    model_edge(ld, li, ls, lv, st);
    @(negedge clk);
    load_en = 0; len_set = 0; start = 0;
    compare_all(req);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin m_nxt[i] = 0; m_cur[i] = 0; end
    m_wp = 0; m_len = DEPTH; m_plen = 1; m_rp = 0; m_rdy = 0; m_play = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R5: start with nothing loaded is dropped and not remembered
    step("R5", 0, 0, 0, 0, 1);
    idle("R5", 2);
    step("R5", 1, 7, 0, 0, 0);
    chk("R5", "busy after late load", int'(busy), 0);

    // R2/R3/R4: load a list, set length 3, replay it
    step("R2", 1, 9, 0, 0, 0);
    step("R2", 1, 2, 1, 3, 0);
    step("R4", 0, 0, 0, 0, 1);
    idle("R4", 2);
    idle("R8", 2);

    // R3: length 0 clamps to 1
    step("R3", 1, 11, 1, 0, 0);
    step("R3", 0, 0, 0, 0, 1);
    idle("R3", 2);

    // R3/R2: length 31 clamps to DEPTH, fill all entries and wrap
    for (int i = 0; i < DEPTH + 2; i++) step("R2", 1, (i * 5 + 3) % 16, 0, 0, 0);
    step("R3", 0, 0, 1, 31, 1);
    // R6/R9/R7: load and change length during replay, early start held
    step("R6", 1, 4, 0, 0, 0);
    step("R9", 1, 6, 1, 2, 0);
    step("R7", 0, 0, 0, 0, 1);
    idle("R7", 16);
    idle("R8", 3);

    // R10: load in the commit cycle
    step("R10", 1, 13, 1, 4, 0);
    step("R10", 1, 8, 0, 0, 1);
    idle("R10", 5);
    step("R10", 0, 0, 0, 0, 1);
    idle("R10", 4);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      bit ld, ls, st;
      ld = ($urandom % 3) == 0;
      ls = ($urandom % 10) == 0;
      st = ($urandom % 7) == 0;
      step("R4", ld, int'($urandom % 16), ls, int'($urandom % 32), st);
    end
    idle("R8", 20);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule